// File: doc/BRIEF.md
# Multi-width leading zero counter

This execution-unit block reports how many zero bits precede the first one bit in a source operand, scanning from the operand's most significant bit downward. A two-bit size code selects a 16-, 32- or 64-bit operand taken from the low end of a 64-bit source bus. Source bits above the selected width are discarded. An operand that is entirely zero yields a count equal to its own width.

Alongside the count the block produces two status flags. `cf` marks an all-zero operand. `zf` marks an operand whose top bit is set, which gives a count of zero. The 64-bit size is legal only while `mode64` is high. An illegal size request raises `size_err` in place of `out_valid`. The block accepts a new operand on every clock and presents the registered outcome one cycle later.

Top module: `lead_zero_unit`

## Requirements
- R1: The count is the number of zero bits from bit (width-1) of the selected operand down to, and not including, the highest set bit within that width.
- R2: The size code `in_size` selects the width: 2'b00 selects 16 bits, 2'b01 selects 32 bits and 2'b10 selects 64 bits.
- R3: When every bit of the selected operand is zero, `result` equals the width (16, 32 or 64), zero-extended to 7 bits.
- R4: `cf` is 1 exactly when the selected operand is all zero and is 0 otherwise.
- R5: `zf` is 1 exactly when `result` is 0, meaning bit (width-1) of the source is set, and is 0 otherwise.
- R6: A request with `in_size` = 2'b10 while `mode64` is low, or with `in_size` = 2'b11, raises `size_err` one cycle later and keeps `out_valid` low for that cycle.
- R7: For the 16- and 32-bit sizes, source bits at positions at or above the width have no effect on `result`, `cf` or `zf`.
- R8: A legal request sampled with `in_valid` high gives `out_valid` high on the next rising edge. A request can be presented on every cycle. Without a request, `out_valid` is low on the next edge.
- R9: While `rst_n` is low at a rising edge, `out_valid` and `size_err` are cleared on that edge, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe; the inputs are sampled while it is high |
| in_size | input | 2 | Operand size code (00=16, 01=32, 10=64, 11=illegal) |
| mode64 | input | 1 | Permits the 64-bit size |
| src | input | 64 | Source operand bus, with the operand right-aligned |
| out_valid | output | 1 | The result and flags belong to a legal request |
| result | output | 7 | Leading zero count |
| cf | output | 1 | Set when the operand is all zero |
| zf | output | 1 | Set when the count is zero |
| size_err | output | 1 | The previous request used an illegal size |

## Verification
The bench builds the block with its default 64-bit bus and 7-bit count. This gives all three widths within one build, including the maximum count of 64, which needs the seventh result bit. With the bus at its full width, single-bit operands can be placed at every position of every size. Random words with nonzero bits above the 16- and 32-bit widths show whether masking holds. Back-to-back requests mixed with idle cycles and illegal sizes exercise the one-cycle timing and the error path.

// File: rtl/lzu_pkg.sv
// Package lzu_pkg
// Shared constants and the operand size encoding for the leading zero counter.
// Assumes the bus is 64 bits wide and that the counts are powers of two.
package lzu_pkg;
    localparam int OP_W  = 64;
    localparam int CNT_W = $clog2(OP_W) + 1;

    typedef enum logic [1:0] {
        SZ16  = 2'b00,
        SZ32  = 2'b01,
        SZ64  = 2'b10,
        SZBAD = 2'b11
    } op_size_e;
endpackage

// File: rtl/lzu_size_mask.sv
// Module lzu_size_mask
// Keeps only the low bits that belong to the selected operand size. It reports
// that width and whether the request is legal. Assumes DATA_W is 64.
module lzu_size_mask
    import lzu_pkg::*;
#(
    parameter int DATA_W = OP_W,
    parameter int CW     = CNT_W
) (
    input  logic [DATA_W-1:0] src,
    input  op_size_e          size,
    input  logic              mode64,
    output logic [DATA_W-1:0] masked,
    output logic [CW-1:0]     width,
    output logic              legal
);
    localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

    // Decode the size code into a width, a bit mask and a legality flag.
    always_comb begin
        case (size)
            SZ16: begin
                width  = CW'(16);
                masked = src & ~(ONES << 16);
                legal  = 1'b1;
            end
            SZ32: begin
                width  = CW'(32);
                masked = src & ~(ONES << 32);
                legal  = 1'b1;
            end
            SZ64: begin
                width  = CW'(DATA_W);
                masked = src;
                legal  = mode64;
            end
            default: begin
                width  = CW'(DATA_W);
                masked = src;
                legal  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lzu_tree.sv
// Module lzu_tree
// Counts the leading zeros of a full DATA_W word with a log-depth tree of
// pairwise merges. Each node carries an all-zero flag and a partial count.
// Assumes DATA_W is a power of two, at least 4.
module lzu_tree #(
    parameter int DATA_W = 64,
    parameter int CW     = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] vec,
    output logic [CW-1:0]     count,
    output logic              all_zero
);
    localparam int LEVELS = $clog2(DATA_W);

    genvar l, i;
    generate
        for (l = 1; l <= LEVELS; l++) begin : g_lvl
            localparam int N = DATA_W >> l;
            logic [N-1:0]   z;
            logic [N*l-1:0] c;
            for (i = 0; i < N; i++) begin : g_node
                if (l == 1) begin : g_leaf
                    // Leaf pair: the higher bit decides a count of 0 or 1.
                    assign z[i] = ~vec[2*i] & ~vec[2*i+1];
                    assign c[i] = ~vec[2*i+1];
                end else begin : g_merge
                    logic         zl, zr;
                    logic [l-2:0] cl, cr;
                    assign zl = g_lvl[l-1].z[2*i+1];
                    assign zr = g_lvl[l-1].z[2*i];
                    assign cl = g_lvl[l-1].c[(2*i+1)*(l-1) +: (l-1)];
                    assign cr = g_lvl[l-1].c[(2*i)*(l-1) +: (l-1)];
                    // Merge: if the upper half is all zero, continue into the lower half.
                    assign z[i] = zl & zr;
                    assign c[i*l +: l] = zl ? {1'b1, cr} : {1'b0, cl};
                end
            end
        end
    endgenerate

    // Root: an all-zero word counts as the full width.
    assign all_zero = g_lvl[LEVELS].z[0];
    assign count    = all_zero ? CW'(DATA_W) : {1'b0, g_lvl[LEVELS].c};
endmodule

// File: rtl/lead_zero_unit.sv
// Module lead_zero_unit
// Top of the multi-width leading zero counter. It masks the operand to the
// selected size and counts on the full bus. It then removes the zeros added
// above the width and registers the count, the flags and the status.
// Assumes the bus is 64 bits wide and the reset is synchronous and active low.
module lead_zero_unit
    import lzu_pkg::*;
#(
    parameter int DATA_W = OP_W,
    parameter int CW     = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_size,
    input  logic              mode64,
    input  logic [DATA_W-1:0] src,
    output logic              out_valid,
    output logic [CW-1:0]     result,
    output logic              cf,
    output logic              zf,
    output logic              size_err
);
    logic [DATA_W-1:0] masked;
    logic [CW-1:0]     width;
    logic              legal;
    logic [CW-1:0]     raw_cnt;
    logic              op_zero;
    logic [CW-1:0]     cnt;
    logic              accept;
    logic              reject;

    lzu_size_mask #(.DATA_W(DATA_W), .CW(CW)) u_mask (
        .src    (src),
        .size   (op_size_e'(in_size)),
        .mode64 (mode64),
        .masked (masked),
        .width  (width),
        .legal  (legal)
    );

    lzu_tree #(.DATA_W(DATA_W), .CW(CW)) u_tree (
        .vec      (masked),
        .count    (raw_cnt),
        .all_zero (op_zero)
    );

    // Remove the zeros that masking placed above the selected width.
    always_comb begin
        cnt    = raw_cnt - (CW'(DATA_W) - width);
        accept = in_valid & legal;
        reject = in_valid & ~legal;
    end

    // Output stage: register the status every cycle and the data on a legal request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            size_err  <= 1'b0;
            result    <= '0;
            cf        <= 1'b0;
            zf        <= 1'b0;
        end else begin
            out_valid <= accept;
            size_err  <= reject;
            if (accept) begin
                result <= cnt;
                cf     <= op_zero;
                zf     <= (cnt == '0);
            end
        end
    end
endmodule

// File: rtl/lzu_checker.sv
// Module lzu_checker
// Temporal properties of lead_zero_unit, attached to it by a bind statement.
// Sees only the ports and the operand's top bits.
module lzu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [1:0] in_size,
    input logic       mode64,
    input logic       msb32,
    input logic       out_valid,
    input logic [6:0] result,
    input logic       cf,
    input logic       zf,
    input logic       size_err
);
    // R3: a count never exceeds the widest operand.
    p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> result <= 7'd64);

    // R4: carry marks a count equal to the width that was requested.
    p_cf_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cf == (result == (($past(in_size) == 2'b00) ? 7'd16 :
                                         ($past(in_size) == 2'b01) ? 7'd32 : 7'd64))));

    // R5: the zero flag tracks a zero count.
    p_zf_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (zf == (result == 7'd0)));

    // R6: an error and a valid result never appear together.
    p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && size_err));

    // R6: an illegal size request is flagged on the next edge.
    p_err_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_size == 2'b11 || (in_size == 2'b10 && !mode64)) |=> size_err);

    // R8: a legal request produces a result on the next edge.
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_size == 2'b00 || in_size == 2'b01 || (in_size == 2'b10 && mode64))
        |=> out_valid);

    // R1: a 32-bit operand with its top bit set counts zero.
    p_msb_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_size == 2'b01 && msb32 |=> out_valid && result == 7'd0);
endmodule

bind lead_zero_unit lzu_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_size   (in_size),
    .mode64    (mode64),
    .msb32     (src[31]),
    .out_valid (out_valid),
    .result    (result),
    .cf        (cf),
    .zf        (zf),
    .size_err  (size_err)
);

// File: tb/lead_zero_unit_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected items, and the monitor pops them one edge later.
module lead_zero_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_size = 2'b00;
    logic        mode64 = 1'b0;
    logic [63:0] src = '0;
    logic        out_valid, cf, zf, size_err;
    logic [6:0]  result;

    typedef struct {
        bit       err;
        bit [6:0] res;
        bit       cf;
        bit       zf;
        string    tag;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   total = 0;
    int   bad = 0;
    bit   mon_on = 1'b0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    lead_zero_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_size(in_size),
        .mode64(mode64), .src(src), .out_valid(out_valid), .result(result),
        .cf(cf), .zf(zf), .size_err(size_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Bit-serial reference model, written from the requirements.
    function automatic exp_t model(input logic [1:0] sz, input logic m64, input logic [63:0] s, input string tag);
        exp_t r;
        int   n;
        int   cnt;
        bit   hit;
        r.tag = tag;
        r.err = (sz == 2'b11) || (sz == 2'b10 && !m64);
        n = (sz == 2'b00) ? 16 : (sz == 2'b01) ? 32 : 64;
        cnt = 0;
        hit = 1'b0;
        for (int k = n - 1; k >= 0; k--) begin
            if (s[k]) hit = 1'b1;
            if (!hit) cnt++;
        end
        r.res = 7'(cnt);
        r.cf  = (cnt == n);
        r.zf  = (cnt == 0);
        return r;
    endfunction

    task automatic drive(input logic [1:0] sz, input logic m64, input logic [63:0] s, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_size  = sz;
        mode64   = m64;
        src      = s;
        q.push_back(model(sz, m64, s, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        src      = '1;
    endtask

    // Monitor: compare just after each edge against the queued expectation.
    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            if (q.size() > 0) begin
                e = q.pop_front();
                if (e.err) begin
                    chk(size_err === 1'b1, {e.tag, " size_err"}, 64'(size_err), 1);
                    chk(out_valid === 1'b0, {e.tag, " out_valid"}, 64'(out_valid), 0);
                end else begin
                    chk(out_valid === 1'b1, {e.tag, " R8 out_valid"}, 64'(out_valid), 1);
                    chk(result === e.res, {e.tag, " result"}, 64'(result), 64'(e.res));
                    chk(cf === e.cf, {e.tag, " R4 cf"}, 64'(cf), 64'(e.cf));
                    chk(zf === e.zf, {e.tag, " R5 zf"}, 64'(zf), 64'(e.zf));
                    chk(size_err === 1'b0, {e.tag, " size_err"}, 64'(size_err), 0);
                end
            end else begin
                chk(out_valid === 1'b0, "R8 idle out_valid", 64'(out_valid), 0);
                chk(size_err === 1'b0, "R8 idle size_err", 64'(size_err), 0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #1000000;
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] r;
        // R9: reset holds the status low even with a request present.
        in_valid = 1'b1;
        in_size  = 2'b11;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(out_valid === 1'b0, "R9 reset out_valid", 64'(out_valid), 0);
            chk(size_err === 1'b0, "R9 reset size_err", 64'(size_err), 0);
        end
        in_valid = 1'b0;
        rst_n    = 1'b1;
        mon_on   = 1'b1;

        // R3 R4: all-zero operand at each size.
        drive(2'b00, 1'b1, 64'h0, "R3 zero16");
        drive(2'b01, 1'b1, 64'h0, "R3 zero32");
        drive(2'b10, 1'b1, 64'h0, "R3 zero64");
        idle();
        // R5: top bit of the operand set.
        drive(2'b00, 1'b0, 64'h8000, "R5 msb16");
        drive(2'b01, 1'b0, 64'h8000_0000, "R5 msb32");
        drive(2'b10, 1'b1, 64'h8000_0000_0000_0000, "R5 msb64");
        idle();
        // R1 R2: one set bit at every position of every size.
        for (int b = 0; b < 16; b++) drive(2'b00, 1'b1, 64'h1 << b, "R1 R2 one16");
        for (int b = 0; b < 32; b++) drive(2'b01, 1'b1, 64'h1 << b, "R1 R2 one32");
        for (int b = 0; b < 64; b++) drive(2'b10, 1'b1, 64'h1 << b, "R1 R2 one64");
        idle();
        // R6: illegal sizes, between legal requests.
        drive(2'b10, 1'b0, 64'h1, "R6 no64");
        drive(2'b01, 1'b0, 64'h1, "R8 after err");
        drive(2'b11, 1'b1, 64'h1, "R6 code3");
        idle();
        idle();
        // R7: nonzero bits above the width, with a zero operand below.
        drive(2'b00, 1'b1, 64'hFFFF_FFFF_FFFF_0000, "R7 R3 upper16");
        drive(2'b01, 1'b1, 64'hFFFF_FFFF_0000_0000, "R7 R3 upper32");
        drive(2'b00, 1'b1, 64'hDEAD_BEEF_CAFE_0001, "R7 low16");
        drive(2'b01, 1'b1, 64'h1234_5678_0000_8000, "R7 low32");
        // Random words shifted right, with random upper bits kept for the narrow sizes.
        for (int k = 0; k < 300; k++) begin
            r = {$urandom, $urandom};
            r = (r >> ($urandom % 64)) | ({$urandom, $urandom} & 64'hFFFF_FFFF_0000_0000);
            drive(2'($urandom % 3), 1'b1, r, "R7 R1 random");
            if (k % 7 == 0) idle();
        end
        idle();
        idle();
        idle();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule